// File: doc/BRIEF.md
# Trace record packer

This block takes captured link-layer transaction headers and rewrites each one as a trace record that a capture engine can write to memory. A header arrives as four 32-bit dwords on a valid/ready input, together with an optional prefix dword and its valid flag, and a one-bit format select. Once the header is accepted, the block sends the record one dword per beat on a valid/ready output stream and marks the final dword.

Two record shapes exist. The short shape is four dwords. Its first dword squeezes a handful of fields from header DW0 next to an 11-bit time value, and the other three dwords are header DW1 to DW3. The long shape is eight dwords. It starts with an all-ones marker dword, then gives the prefix, the four header dwords in full, a zero pad and a 32-bit time value. The time value comes from a counter that runs freely from reset, and it is sampled on the cycle the header is accepted.

The controller has three states. `ST_IDLE` holds the header input ready. `ST_SHORT` sends a short record. `ST_LONG` sends a long record. A handshake in `ST_IDLE` moves the controller to `ST_SHORT` or `ST_LONG` according to the format select. In either sending state, the handshake on the final dword returns it to `ST_IDLE`. Any other beat stays in the state and moves on to the next dword.

Top module: `trace_rec_packer`

## Requirements
- R1: During reset and in the first cycle after reset, `out_valid` is 0 and `hdr_ready` is 1.
- R2: `hdr_ready` is 0 from the cycle after a header handshake until the final dword of that record has been transferred. In the cycle after that transfer it is 1 again.
- R3: `fmt_sel`=0 produces a record of 4 dwords and `fmt_sel`=1 produces 8 dwords. `out_last` is 1 only on the final dword.
- R4: Short dword 0 is built as follows. [31:30] is header DW0[30:29]. [29:25] is DW0[28:24]. [24] is DW0[23]. [23] is DW0[19]. [22] is DW0[16]. [21] is DW0[13]. [20:11] is DW0[9:0]. [10:0] is the time value's low 11 bits.
- R5: Short dwords 1 to 3 are header DW1 to DW3 unchanged. Header DWk sits in `hdr_data[32k+31:32k]`.
- R6: Long dword 0 is 32'hFFFFFFFF.
- R7: Long dword 1 is `pfx_data` when `pfx_valid` was 1 at the handshake, and 0 otherwise.
- R8: Long dwords 2 to 5 are header DW0 to DW3, and long dword 6 is 0.
- R9: The time counter is 0 in the first cycle after reset and adds 1 each clock. A record carries the counter value of its handshake cycle: the low 32 bits in long dword 7, and the low 11 bits in short dword 0.
- R10: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data` and `out_last` hold their values.
- R11: Header, prefix and format inputs are captured at the handshake. Changing them while a record is being sent does not alter that record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hdr_valid | input | 1 | Header offered |
| hdr_ready | output | 1 | Header can be taken |
| hdr_data | input | 128 | Header dwords, DW0 in the low 32 bits |
| pfx_data | input | 32 | Prefix dword |
| pfx_valid | input | 1 | Prefix present |
| fmt_sel | input | 1 | 0 short record, 1 long record |
| out_valid | output | 1 | Record dword offered |
| out_ready | input | 1 | Sink takes the dword |
| out_data | output | 32 | Record dword |
| out_last | output | 1 | Final dword of record |

## Verification
The assertions assume that the sink follows the usual stream rule: a dword counts as moved only on a cycle where both valid and ready are high. They also assume that reset is held for at least one clock edge, so that the counter-step check has a defined previous value. The stimulus drives `out_ready` from a random draw on every cycle, which gives both stalled and flowing beats. The bench also changes the header, prefix and format inputs in the middle of a record, so that the check on what is captured at the handshake sees real input changes.

// File: rtl/trp_pkg.sv
package trp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHORT = 2'd1,
        ST_LONG  = 2'd2
    } trp_state_e;

    localparam int unsigned WORD_W   = 32;
    localparam int unsigned HDR_WDS  = 4;
    localparam int unsigned SHORT_WDS = 4;
    localparam int unsigned LONG_WDS  = 8;
    localparam int unsigned IDX_W    = $clog2(LONG_WDS);
    localparam int unsigned STAMP_SHORT_W = 11;
endpackage

// File: rtl/trp_stamp.sv
module trp_stamp #(
    parameter int unsigned TS_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [TS_W-1:0] ts_cnt
);
    always_ff @(posedge clk) begin
        if (!rst_n) ts_cnt <= '0;
        else        ts_cnt <= ts_cnt + 1'b1;
    end

    // R9
    ts_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ts_cnt == $past(ts_cnt) + 1'b1);
endmodule

// File: rtl/trp_word_sel.sv
module trp_word_sel
    import trp_pkg::*;
#(
    parameter int unsigned TS_W = 32
) (
    input  logic                       is_long,
    input  logic [IDX_W-1:0]           idx,
    input  logic [HDR_WDS*WORD_W-1:0]  hdr,
    input  logic [WORD_W-1:0]          pfx,
    input  logic                       pfx_ok,
    input  logic [TS_W-1:0]            ts,
    output logic [WORD_W-1:0]          word
);
    logic [WORD_W-1:0] hw [HDR_WDS];
    logic [WORD_W-1:0] short_w0;
    logic [WORD_W-1:0] short_word;
    logic [WORD_W-1:0] long_word;

    for (genvar g = 0; g < HDR_WDS; g++) begin : g_split
        assign hw[g] = hdr[g*WORD_W +: WORD_W];
    end

    assign short_w0 = {hw[0][30:29], hw[0][28:24], hw[0][23], hw[0][19],
                       hw[0][16], hw[0][13], hw[0][9:0],
                       ts[STAMP_SHORT_W-1:0]};

    always_comb begin
        unique case (idx[1:0])
            2'd0:    short_word = short_w0;
            2'd1:    short_word = hw[1];
            2'd2:    short_word = hw[2];
            default: short_word = hw[3];
        endcase
    end

    always_comb begin
        unique case (idx)
            3'd0:    long_word = '1;
            3'd1:    long_word = pfx_ok ? pfx : '0;
            3'd2:    long_word = hw[0];
            3'd3:    long_word = hw[1];
            3'd4:    long_word = hw[2];
            3'd5:    long_word = hw[3];
            3'd6:    long_word = '0;
            default: long_word = ts[WORD_W-1:0];
        endcase
    end

    assign word = is_long ? long_word : short_word;
endmodule

// File: rtl/trace_rec_packer.sv
module trace_rec_packer
    import trp_pkg::*;
#(
    parameter int unsigned TS_W = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      hdr_valid,
    output logic                      hdr_ready,
    input  logic [HDR_WDS*WORD_W-1:0] hdr_data,
    input  logic [WORD_W-1:0]         pfx_data,
    input  logic                      pfx_valid,
    input  logic                      fmt_sel,
    output logic                      out_valid,
    input  logic                      out_ready,
    output logic [WORD_W-1:0]         out_data,
    output logic                      out_last
);
    localparam logic [IDX_W-1:0] SHORT_END = IDX_W'(SHORT_WDS - 1);
    localparam logic [IDX_W-1:0] LONG_END  = IDX_W'(LONG_WDS - 1);

    trp_state_e state_q, state_d;
    logic [IDX_W-1:0]           idx_q;
    logic [HDR_WDS*WORD_W-1:0]  hdr_q;
    logic [WORD_W-1:0]          pfx_q;
    logic                       pfx_ok_q;
    logic [TS_W-1:0]            ts_q;
    logic [TS_W-1:0]            ts_cnt;
    logic                       take_hdr;
    logic                       beat;
    logic                       at_end;

    trp_stamp #(.TS_W(TS_W)) u_stamp (
        .clk    (clk),
        .rst_n  (rst_n),
        .ts_cnt (ts_cnt)
    );

    trp_word_sel #(.TS_W(TS_W)) u_sel (
        .is_long (state_q == ST_LONG),
        .idx     (idx_q),
        .hdr     (hdr_q),
        .pfx     (pfx_q),
        .pfx_ok  (pfx_ok_q),
        .ts      (ts_q),
        .word    (out_data)
    );

    assign take_hdr = hdr_valid && hdr_ready;
    assign beat     = out_valid && out_ready;
    assign at_end   = (state_q == ST_LONG) ? (idx_q == LONG_END)
                                           : (idx_q == SHORT_END);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (take_hdr) state_d = fmt_sel ? ST_LONG : ST_SHORT;
            ST_SHORT: if (beat && at_end) state_d = ST_IDLE;
            ST_LONG:  if (beat && at_end) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        hdr_ready = (state_q == ST_IDLE);
        out_valid = (state_q != ST_IDLE);
        out_last  = out_valid && at_end;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q    <= '0;
            hdr_q    <= '0;
            pfx_q    <= '0;
            pfx_ok_q <= 1'b0;
            ts_q     <= '0;
        end else if (take_hdr) begin
            idx_q    <= '0;
            hdr_q    <= hdr_data;
            pfx_q    <= pfx_data;
            pfx_ok_q <= pfx_valid;
            ts_q     <= ts_cnt;
        end else if (beat) begin
            idx_q    <= at_end ? '0 : idx_q + 1'b1;
        end
    end

    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

    // R2
    busy_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_hdr |=> (out_valid && !hdr_ready));

    // R2
    free_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat && out_last) |=> (hdr_ready && !out_valid));

    // R3
    last_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat && !out_last) |=> out_valid);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (hdr_ready && !out_valid));
endmodule

// File: tb/trace_rec_packer_tb.sv
module trace_rec_packer_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         hdr_valid = 1'b0;
    logic         hdr_ready;
    logic [127:0] hdr_data = '0;
    logic [31:0]  pfx_data = '0;
    logic         pfx_valid = 1'b0;
    logic         fmt_sel = 1'b0;
    logic         out_valid;
    logic         out_ready = 1'b0;
    logic [31:0]  out_data;
    logic         out_last;

    int unsigned n_chk = 0;
    int unsigned n_bad = 0;
    logic [31:0] tb_cnt = '0;

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) tb_cnt <= '0;
        else        tb_cnt <= tb_cnt + 1;
    end

    trace_rec_packer u_dut (
        .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_ready(hdr_ready),
        .hdr_data(hdr_data), .pfx_data(pfx_data), .pfx_valid(pfx_valid),
        .fmt_sel(fmt_sel), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_last(out_last)
    );

    function automatic logic [31:0] exp_word(input logic [127:0] h, input logic [31:0] p,
                                             input logic pv, input logic lng,
                                             input logic [31:0] ts, input int k);
        logic [31:0] d0;
        d0 = h[31:0];
        if (!lng) begin
            if (k == 0)
                return {d0[30:29], d0[28:24], d0[23], d0[19], d0[16], d0[13],
                        d0[9:0], ts[10:0]};
            return h[32*k +: 32];
        end
        case (k)
            0: return 32'hFFFF_FFFF;
            1: return pv ? p : 32'h0;
            2, 3, 4, 5: return h[32*(k-2) +: 32];
            6: return 32'h0;
            default: return ts;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_rec(input logic [127:0] h, input logic [31:0] p, input logic pv,
                           input logic lng, input int stall_pct);
        logic [31:0] ts;
        int n;
        int guard;
        n = lng ? 8 : 4;
        @(negedge clk);
        hdr_valid = 1'b1; hdr_data = h; pfx_data = p; pfx_valid = pv; fmt_sel = lng;
        check("R2 ready when idle", {31'b0, hdr_ready}, 32'd1);
        ts = tb_cnt;
        @(posedge clk);
        @(negedge clk);
        hdr_valid = 1'b0;
        // R11: scramble inputs while the record is being sent
        hdr_data = {$urandom, $urandom, $urandom, $urandom};
        pfx_data = $urandom; pfx_valid = ~pv; fmt_sel = ~lng;
        for (int k = 0; k < n; k++) begin
            guard = 0;
            forever begin
                out_ready = ($urandom_range(0, 99) >= stall_pct);
                check("R2 ready low while busy", {31'b0, hdr_ready}, 32'd0);
                check("R3 valid during record", {31'b0, out_valid}, 32'd1);
                if (out_valid && out_ready) break;
                guard++;
                if (guard > 50) break;
                @(posedge clk);
                @(negedge clk);
                check("R10 hold while stalled", out_data, exp_word(h, p, pv, lng, ts, k));
            end
            if (k == 0 && lng)         check("R6 marker", out_data, exp_word(h, p, pv, lng, ts, k));
            else if (k == 0)           check("R4 short word0", out_data, exp_word(h, p, pv, lng, ts, k));
            else if (!lng)             check("R5 short header copy", out_data, exp_word(h, p, pv, lng, ts, k));
            else if (k == 1)           check("R7 prefix", out_data, exp_word(h, p, pv, lng, ts, k));
            else if (k == 7)           check("R9 long time", out_data, exp_word(h, p, pv, lng, ts, k));
            else                       check("R8 long body R11", out_data, exp_word(h, p, pv, lng, ts, k));
            check("R3 last flag", {31'b0, out_last}, {31'b0, k == n - 1});
            @(posedge clk);
            @(negedge clk);
        end
        out_ready = 1'b0;
        check("R2 ready after last", {31'b0, hdr_ready}, 32'd1);
        check("R3 no extra word", {31'b0, out_valid}, 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd7541));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset valid", {31'b0, out_valid}, 32'd0);
        check("R1 reset ready", {31'b0, hdr_ready}, 32'd1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset valid", {31'b0, out_valid}, 32'd0);
        check("R1 after reset ready", {31'b0, hdr_ready}, 32'd1);
        // directed corners
        run_rec(128'h44443333_22221111_DEADBEEF_6A5B2C3D, 32'h0, 1'b0, 1'b0, 0);
        run_rec(128'h44443333_22221111_DEADBEEF_6A5B2C3D, 32'hCAFE0001, 1'b1, 1'b1, 0);
        run_rec(128'h0, 32'h12345678, 1'b0, 1'b1, 50);
        run_rec({128{1'b1}}, 32'hFFFFFFFF, 1'b1, 1'b0, 50);
        run_rec({4{32'hA0A0A0A0}}, 32'h5, 1'b1, 1'b1, 90);
        // random mix, including a late start so the short time field wraps
        for (int i = 0; i < 60; i++) begin
            if (i == 30) repeat (2100) @(posedge clk);
            run_rec({$urandom, $urandom, $urandom, $urandom}, $urandom,
                    1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                    $urandom_range(0, 70));
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule